// File: doc/BRIEF.md
# Sticky Error and Summary Status Word

This block gathers per-condition error and warning inputs from a readout unit into a 32-bit status word. Each bit position has a fixed class. Sticky bits mark conditions that need a reset; they stay set until a global clear. Per-event bits mark bad-event conditions; they are collected over one event and start again at the next begin-of-event strobe. Level bits follow their input directly. Four summary bits are ORs of fixed subsets of the others.

A packet framer reads two values. The begin-of-event strobe captures a snapshot of the word for the event header. The live word, which includes everything seen during the event, goes into the trailer. A per-event condition that arrives after an end-of-event strobe and before the next begin-of-event strobe is held pending. It is not charged to the event whose trailer has already gone out, and it joins the next event when that event begins. A separate one-bit flag shows whether a reset is needed.

Bit classes, by word index: sticky {2,3,4,5,6,7,10,11,25,26}; per-event {0,1,8,9,16,17,18,19,23,27}; level {20,21,22,24,28,29,30,31}; summary {12,13,14,15}.

Top module: `evt_status_collect`

## Requirements
- R1: A pulse on a sticky-class input sets its bit on the next clock edge. The bit then stays set until the global clear input is high at a clock edge.
- R2: A per-event bit set during an event stays set until the next begin-of-event strobe. That strobe clears it on the same edge at which the snapshot is taken, so the snapshot still shows the bit.
- R3: A condition input that is high on the same edge as a begin-of-event strobe or a global clear is kept in the word after that edge.
- R4: A per-event pulse that arrives after an end-of-event strobe and before the next begin-of-event strobe leaves the live word unchanged. It appears in the live word after the next begin-of-event strobe.
- R5: Level-class bits of the live word equal their inputs in the same cycle. Nothing is stored for them.
- R6: Bit 15 is the OR of all sticky bits, and `reset_req_o` equals bit 15.
- R7: Bit 14 is the OR of bits 0, 1, 3, 4, 5, 6, 7, 8, 9, 11, 16, 17, 18, 19 and 27.
- R8: Bit 13 is the OR of bits 10 and 23. Bit 12 follows bit 29.
- R9: Inputs at the summary positions 12 to 15 have no effect on the word.
- R10: On a begin-of-event strobe, `boe_word_o` takes the live word as it stood before that edge, and it holds that value at every other edge, global clear included.
- R11: An active-low asynchronous reset clears all stored state at once: the live word, the snapshot, the flag and the event state. After reset the block is between events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gclr_i | input | 1 | Synchronous global clear of sticky and per-event state |
| boe_i | input | 1 | Begin-of-event strobe |
| eoe_i | input | 1 | End-of-event strobe |
| cond_i | input | 32 | Condition inputs, one per word index |
| boe_word_o | output | 32 | Status snapshot taken at begin of event |
| live_word_o | output | 32 | Current status word |
| reset_req_o | output | 1 | Reset-required flag |

## Verification
If a sticky flop is lost or cleared wrongly, the live word and `reset_req_o` show it on the very next edge, and so does every later snapshot. If the event-phase flop is wrong, pending conditions show up in the trailer one event early, or a begin-of-event strobe fails to bring them in. Either fault appears in `live_word_o` within one cycle of the strobe concerned. If the snapshot is taken after the clear instead of before it, `boe_word_o` drops the previous event's per-event bits on the strobe edge itself.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int unsigned SW = 32;

  localparam logic [SW-1:0] STICKY_M = 32'h0600_0CFC;
  localparam logic [SW-1:0] EVENT_M  = 32'h088F_0303;
  localparam logic [SW-1:0] LEVEL_M  = 32'hF170_0000;
  localparam logic [SW-1:0] SUM_M    = 32'h0000_F000;

  // summary sources
  localparam logic [SW-1:0] RST_SRC  = STICKY_M;
  localparam logic [SW-1:0] BAD_SRC  = 32'h080F_0BFB;
  localparam logic [SW-1:0] WARN_SRC = 32'h0080_0400;
  localparam logic [SW-1:0] NF_SRC   = 32'h2000_0000;

  localparam int unsigned SUM_NF   = 12;
  localparam int unsigned SUM_WARN = 13;
  localparam int unsigned SUM_BAD  = 14;
  localparam int unsigned SUM_RST  = 15;

  typedef enum logic {PH_IDLE = 1'b0, PH_EVT = 1'b1} phase_e;
endpackage

// File: rtl/sts_sticky_bank.sv
module sts_sticky_bank #(
  parameter int unsigned          W    = 32,
  parameter logic [W-1:0]         MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gclr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] hold;

  // clear first, then same-cycle sets survive
  assign hold = gclr_i ? '0 : q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (hold | set_i) & MASK;
  end

  assign q_o = q;

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gclr_i |=> ((q & $past(q)) == $past(q))); // R1
endmodule

// File: rtl/sts_event_bank.sv
module sts_event_bank
  import evt_status_pkg::*;
#(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         gclr_i,
  input  logic         boe_i,
  input  logic         eoe_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] ev_o,
  output logic         in_evt_o
);
  phase_e       ph_q;
  logic [W-1:0] ev_q, pd_q;
  logic [W-1:0] ev_base, pd_base, set_m;

  assign set_m   = set_i & MASK;
  assign ev_base = gclr_i ? '0 : ev_q;
  assign pd_base = gclr_i ? '0 : pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE;
      ev_q <= '0;
      pd_q <= '0;
    end else if (boe_i) begin
      ph_q <= PH_EVT;
      ev_q <= pd_base | set_m;
      pd_q <= '0;
    end else if (ph_q == PH_EVT) begin
      ev_q <= ev_base | set_m;
      pd_q <= pd_base;
      if (eoe_i) ph_q <= PH_IDLE;
    end else begin
      ev_q <= ev_base;
      pd_q <= pd_base | set_m;
    end
  end

  assign ev_o     = ev_q;
  assign in_evt_o = (ph_q == PH_EVT);

  AST_PEND_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_EVT) |-> (pd_q == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph_q == PH_IDLE) && !boe_i && !gclr_i) |=> $stable(ev_q)); // R4
endmodule

// File: rtl/sts_summary.sv
module sts_summary
  import evt_status_pkg::*;
(
  input  logic [SW-1:0] latched_i,
  input  logic [SW-1:0] level_i,
  output logic [SW-1:0] word_o
);
  logic [SW-1:0] base;

  always_comb begin
    base = (latched_i & ~SUM_M) | (level_i & LEVEL_M);
    word_o = base;
    word_o[SUM_RST]  = |(base & RST_SRC);
    word_o[SUM_BAD]  = |(base & BAD_SRC);
    word_o[SUM_WARN] = |(base & WARN_SRC);
    word_o[SUM_NF]   = |(base & NF_SRC);
  end
endmodule

// File: rtl/evt_status_collect.sv
module evt_status_collect
  import evt_status_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gclr_i,
  input  logic          boe_i,
  input  logic          eoe_i,
  input  logic [SW-1:0] cond_i,
  output logic [SW-1:0] boe_word_o,
  output logic [SW-1:0] live_word_o,
  output logic          reset_req_o
);
  logic [SW-1:0] sticky_q, ev_q, live, snap_q;
  logic          in_evt;

  sts_sticky_bank #(.W(SW), .MASK(STICKY_M)) u_sticky (
    .clk_i (clk_i), .rst_ni (rst_ni), .gclr_i (gclr_i),
    .set_i (cond_i), .q_o (sticky_q)
  );

  sts_event_bank #(.W(SW), .MASK(EVENT_M)) u_event (
    .clk_i (clk_i), .rst_ni (rst_ni), .gclr_i (gclr_i),
    .boe_i (boe_i), .eoe_i (eoe_i), .set_i (cond_i),
    .ev_o (ev_q), .in_evt_o (in_evt)
  );

  sts_summary u_sum (
    .latched_i (sticky_q | ev_q),
    .level_i   (cond_i),
    .word_o    (live)
  );

  // snapshot sees the word before the per-event clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_q <= '0;
    else if (boe_i) snap_q <= live;
  end

  assign boe_word_o  = snap_q;
  assign live_word_o = live;
  assign reset_req_o = live[SUM_RST];

  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boe_i |=> $stable(snap_q)); // R10
  AST_RST_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(cond_i & STICKY_M)) |=> reset_req_o); // R6
  AST_BOE_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boe_i |=> in_evt); // R4
  AST_SUM_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sticky_q | ev_q) == '0 && (cond_i & LEVEL_M) == '0) |-> ((live & SUM_M) == '0)); // R9
endmodule

// File: tb/sim_evt_status_collect.sv
module sim_evt_status_collect;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        gclr, boe, eoe;
  logic [31:0] cond;
  logic [31:0] snap, live;
  logic        rflag;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  evt_status_collect u0 (
    .clk_i (clk), .rst_ni (rst_ni), .gclr_i (gclr), .boe_i (boe), .eoe_i (eoe),
    .cond_i (cond), .boe_word_o (snap), .live_word_o (live), .reset_req_o (rflag)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        g, b, e;
    logic [31:0] c, exp_live, exp_snap;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{4'd10, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}, // R10 first boe
    '{4'd7,  1'b0, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_4001, 32'h0000_0000}, // R7 R2
    '{4'd5,  1'b0, 1'b0, 1'b0, 32'h2000_0000, 32'h2000_5001, 32'h0000_0000}, // R5 R8 nf
    '{4'd5,  1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_4001, 32'h0000_0000}, // R5 level drops, eoe
    '{4'd4,  1'b0, 1'b0, 1'b0, 32'h0008_0000, 32'h0000_4001, 32'h0000_0000}, // R4 pending
    '{4'd2,  1'b0, 1'b1, 1'b0, 32'h0080_0000, 32'h0088_6000, 32'h0000_4001}, // R2 R3 R4 R8
    '{4'd1,  1'b0, 1'b0, 1'b0, 32'h0000_0040, 32'h0088_E040, 32'h0000_4001}, // R1 R6
    '{4'd1,  1'b0, 1'b1, 1'b0, 32'h0000_0400, 32'h0000_E440, 32'h0088_E040}, // R1 R2 R8
    '{4'd9,  1'b0, 1'b0, 1'b0, 32'h0000_F000, 32'h0000_E440, 32'h0088_E040}, // R9
    '{4'd3,  1'b1, 1'b0, 1'b0, 32'h0000_0004, 32'h0000_8004, 32'h0088_E040}, // R3 R1 R10
    '{4'd1,  1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0088_E040}, // R1 clear
    '{4'd5,  1'b0, 1'b0, 1'b0, 32'hF170_0000, 32'hF170_1000, 32'h0088_E040}, // R5 R8
    '{4'd10, 1'b0, 1'b1, 1'b0, 32'h0000_0002, 32'h0000_4002, 32'h0000_0000}, // R10 R3
    '{4'd6,  1'b0, 1'b0, 1'b0, 32'h0400_0000, 32'h0400_C002, 32'h0000_0000}, // R6
    '{4'd2,  1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0400_8000, 32'h0400_C002}  // R2 R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  initial begin
    gclr = 1'b0; boe = 1'b0; eoe = 1'b0; cond = '0;
    #1;
    // R11 state during reset
    check("R11 live in reset", live, 32'h0);
    check("R11 snap in reset", snap, 32'h0);
    check("R11 flag in reset", {31'h0, rflag}, 32'h0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      gclr = TBL[i].g; boe = TBL[i].b; eoe = TBL[i].e; cond = TBL[i].c;
      @(posedge clk);
      #1;
      check($sformatf("R%0d live vec %0d", TBL[i].req, i), live, TBL[i].exp_live);
      check($sformatf("R%0d snap vec %0d", TBL[i].req, i), snap, TBL[i].exp_snap);
      check($sformatf("R6 flag vec %0d", i), {31'h0, rflag}, {31'h0, TBL[i].exp_live[15]});
    end
    @(negedge clk);
    gclr = 1'b0; boe = 1'b0; eoe = 1'b0; cond = '0;
    // R11 asynchronous reset mid-run, no clock edge in between
    #1 rst_ni = 1'b0;
    #1;
    check("R11 live async", live, 32'h0);
    check("R11 snap async", snap, 32'h0);
    check("R11 flag async", {31'h0, rflag}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R11 idle after reset: per-event pulse stays pending
    @(negedge clk); cond = 32'h0800_0000;
    @(posedge clk); #1 check("R11 idle after reset", live, 32'h0);
    @(negedge clk); cond = '0; boe = 1'b1;
    @(posedge clk); #1 check("R4 pending joins event", live, 32'h0800_4000);
    @(negedge clk); boe = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule